// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

A 16-bit timer that steps by one on each cycle where a shared prescaler tick is present and the run bit is set. The count direction comes from an external direction pin, but only when the down-count enable is set. Otherwise the timer always counts up. The timer reloads itself at each end of its range. When it counts up past the all-ones value, it loads the value held in the reload register. When it counts down and the count matches the reload register, the next step loads all ones.

Each wrap does three things. It sets a sticky interrupt flag. It toggles an extension flag, but only in the mode where the direction pin is honoured. It toggles an optional output pin, but only when the output enable is set. Software can load the count and the reload register through write strobes. A count write always wins over a step or a reload in the same cycle.

Top module: `tmr_updown`

## Requirements
- R1: After the asynchronous reset (rst_ni low), cnt_o, rld_o, irq_o, ext_o and tog_o are all zero.
- R2: The count changes only on a clock edge where run_i=1 and tick_i=1, or where cnt_wr_i=1. When run_i=0 or tick_i=0, a step has no effect.
- R3: In a step while counting up, a count of 0xFFFF loads rld_o and is a wrap. Any other count increments by one.
- R4: In a step while counting down, a count equal to rld_o loads 0xFFFF and is a wrap. Any other count decrements by one.
- R5: With dcen_i=1, dir_i=0 selects down and dir_i=1 selects up. With dcen_i=0 the timer counts up and dir_i has no effect.
- R6: A wrap sets irq_o. irq_o stays at 1 until irq_clr_i=1. If irq_clr_i=1 in the same cycle as a wrap, the flag stays set.
- R7: ext_o toggles on a wrap only when dcen_i=1. With dcen_i=0 it holds its value.
- R8: tog_o toggles on a wrap only when oe_i=1. With oe_i=0 it holds its value.
- R9: cnt_wr_i=1 loads cnt_wdata_i on the next edge and overrides any step or reload, with no wrap. rld_wr_i=1 loads rld_wdata_i into rld_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler count-enable tick |
| run_i | input | 1 | Run control |
| dcen_i | input | 1 | Down-count enable (honour dir_i) |
| dir_i | input | 1 | Direction pin: 0 down, 1 up |
| oe_i | input | 1 | Toggle output enable |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload register write data |
| irq_clr_i | input | 1 | Interrupt flag clear |
| cnt_o | output | 16 | Current count |
| rld_o | output | 16 | Reload register |
| irq_o | output | 1 | Overflow/underflow interrupt flag |
| ext_o | output | 1 | Extension flag, toggles on a wrap |
| tog_o | output | 1 | Toggle output |

## Verification
The hardest cases to reach are wraps, because from reset a wrap needs up to 65536 ticks. The stimulus avoids this by writing the count to the value just short of the wrap, or to the reload value, and then stepping. The reload register is also set to zero to test the down-count wrap at the bottom edge. The cases that also collide with another event are steered the same way: a count write in the same cycle as a tick, a flag clear in the same cycle as a wrap, and a wrap while the output enable or the down enable is low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/tmr_dir.sv
module tmr_dir
  import tmr_pkg::*;
(
  input  logic dcen_i,
  input  logic dir_pin_i,
  output dir_e dir_o
);
  always_comb begin
    if (dcen_i && !dir_pin_i) dir_o = DIR_DOWN;
    else                      dir_o = DIR_UP;
  end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rld_i,
  input  dir_e         dir_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};

  always_comb begin
    wrap_o = 1'b0;
    if (dir_i == DIR_UP) begin
      if (cnt_i == CntMax) begin
        nxt_o  = rld_i;
        wrap_o = 1'b1;
      end else begin
        nxt_o = cnt_i + 1'b1;
      end
    end else begin
      if (cnt_i == rld_i) begin
        nxt_o  = CntMax;
        wrap_o = 1'b1;
      end else begin
        nxt_o = cnt_i - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic dcen_i,
  input  logic oe_i,
  output logic irq_o,
  output logic ext_o,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      ext_o <= 1'b0;
      tog_o <= 1'b0;
    end else begin
      // set wins over clear
      if (evt_i)      irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
      if (evt_i && dcen_i) ext_o <= ~ext_o;
      if (evt_i && oe_i)   tog_o <= ~tog_o;
    end
  end
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         dcen_i,
  input  logic         dir_i,
  input  logic         oe_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         irq_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         irq_o,
  output logic         ext_o,
  output logic         tog_o
);
  dir_e         dir;
  logic [W-1:0] cnt_nxt;
  logic         wrap;
  logic         step;
  logic         evt;

  assign step = run_i && tick_i && !cnt_wr_i;
  assign evt  = step && wrap;

  tmr_dir u_dir (
    .dcen_i   (dcen_i),
    .dir_pin_i(dir_i),
    .dir_o    (dir)
  );

  tmr_step #(.W(W)) u_step (
    .cnt_i (cnt_o),
    .rld_i (rld_o),
    .dir_i (dir),
    .nxt_o (cnt_nxt),
    .wrap_o(wrap)
  );

  tmr_flags u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .clr_i (irq_clr_i),
    .dcen_i(dcen_i),
    .oe_i  (oe_i),
    .irq_o (irq_o),
    .ext_o (ext_o),
    .tog_o (tog_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      rld_o <= '0;
    end else begin
      if (cnt_wr_i)  cnt_o <= cnt_wdata_i;
      else if (step) cnt_o <= cnt_nxt;
      if (rld_wr_i)  rld_o <= rld_wdata_i;
    end
  end
endmodule

// File: rtl/tmr_updown_chk.sv
module tmr_updown_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         run_i,
  input logic         dcen_i,
  input logic         dir_i,
  input logic         oe_i,
  input logic         cnt_wr_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic         irq_clr_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] rld_o,
  input logic         irq_o,
  input logic         ext_o,
  input logic         tog_o
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && tick_i) && !cnt_wr_i) |=> $stable(cnt_o));

  a_r3_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_wr_i && (!dcen_i || dir_i) && cnt_o == {W{1'b1}})
      |=> (cnt_o == $past(rld_o)) && irq_o);

  a_r4_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_wr_i && dcen_i && !dir_i && cnt_o == rld_o)
      |=> (cnt_o == {W{1'b1}}) && irq_o);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r7_ext_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dcen_i |=> $stable(ext_o));

  a_r8_tog_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> $stable(tog_o));

  a_r9_wr_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));
endmodule

bind tmr_updown tmr_updown_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .run_i      (run_i),
  .dcen_i     (dcen_i),
  .dir_i      (dir_i),
  .oe_i       (oe_i),
  .cnt_wr_i   (cnt_wr_i),
  .cnt_wdata_i(cnt_wdata_i),
  .irq_clr_i  (irq_clr_i),
  .cnt_o      (cnt_o),
  .rld_o      (rld_o),
  .irq_o      (irq_o),
  .ext_o      (ext_o),
  .tog_o      (tog_o)
);

// File: tb/tb_tmr_updown.sv
module tb_tmr_updown;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, run = 0, dcen = 0, dir = 0, oe = 0;
  logic cnt_wr = 0, rld_wr = 0, irq_clr = 0;
  logic [15:0] cnt_wd = '0, rld_wd = '0;
  logic [15:0] cnt, rld;
  logic irq, ext, tog;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_updown dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
    .dcen_i(dcen), .dir_i(dir), .oe_i(oe),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd),
    .rld_wr_i(rld_wr), .rld_wdata_i(rld_wd), .irq_clr_i(irq_clr),
    .cnt_o(cnt), .rld_o(rld), .irq_o(irq), .ext_o(ext), .tog_o(tog)
  );

  // {dcen,dir,run,tick,wr,wdata[15:0],exp_cnt[15:0],exp_irq,exp_ext,exp_tog}
  localparam logic [39:0] VEC [12] = '{
    {5'b00001, 16'hFFFE, 16'hFFFE, 3'b000},  // R9 write, R2 no run
    {5'b00110, 16'h0000, 16'hFFFF, 3'b000},  // R3 up
    {5'b00110, 16'h0000, 16'hFFF0, 3'b101},  // R3 wrap, R6, R8
    {5'b00100, 16'h0000, 16'hFFF0, 3'b101},  // R2 no tick
    {5'b00010, 16'h0000, 16'hFFF0, 3'b101},  // R2 no run
    {5'b10110, 16'h0000, 16'hFFFF, 3'b110},  // R4 wrap, R7, R8
    {5'b10110, 16'h0000, 16'hFFFE, 3'b110},  // R4 down
    {5'b11110, 16'h0000, 16'hFFFF, 3'b110},  // R5 dir up
    {5'b00110, 16'h0000, 16'hFFF0, 3'b111},  // R5 dir ignored, R7 hold
    {5'b10111, 16'h1234, 16'h1234, 3'b111},  // R9 write wins
    {5'b10110, 16'h0000, 16'h1233, 3'b111},  // R4 down
    {5'b11110, 16'h0000, 16'h1234, 3'b111}   // R5 up
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    #3;
    chk("R1 cnt", cnt, 16'h0);
    chk("R1 flags", {13'b0, irq, ext, tog}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    oe = 1;
    rld_wr = 1; rld_wd = 16'hFFF0;
    cyc();
    rld_wr = 0;
    chk("R9 rld", rld, 16'hFFF0);
    chk("R2 idle cnt", cnt, 16'h0);

    for (int i = 0; i < 12; i++) begin
      {dcen, dir, run, tick, cnt_wr} = VEC[i][39:35];
      cnt_wd = VEC[i][34:19];
      cyc();
      chk($sformatf("R2-R9 vec%0d cnt", i), cnt, VEC[i][18:3]);
      chk($sformatf("R6-R8 vec%0d flags", i), {13'b0, irq, ext, tog}, {13'b0, VEC[i][2:0]});
    end
    {dcen, dir, run, tick, cnt_wr} = 5'b0;

    // R6 clear
    irq_clr = 1; cyc(); irq_clr = 0;
    chk("R6 clear", {15'b0, irq}, 16'h0);
    cyc();
    chk("R6 stays clear", {15'b0, irq}, 16'h0);

    // R6 set wins over clear in wrap cycle
    cnt_wr = 1; cnt_wd = 16'hFFFF; cyc(); cnt_wr = 0;
    run = 1; tick = 1; irq_clr = 1; cyc();
    run = 0; tick = 0; irq_clr = 0;
    chk("R6 set wins cnt", cnt, 16'hFFF0);
    chk("R6 set wins irq", {15'b0, irq}, 16'h1);
    chk("R8 toggle", {15'b0, tog}, 16'h0);

    // R8 oe low holds tog
    oe = 0;
    cnt_wr = 1; cnt_wd = 16'hFFFF; cyc(); cnt_wr = 0;
    run = 1; tick = 1; cyc(); run = 0; tick = 0;
    chk("R3 wrap oe0 cnt", cnt, 16'hFFF0);
    chk("R8 tog held", {15'b0, tog}, 16'h0);

    // R4 zero reload bottom edge
    rld_wr = 1; rld_wd = 16'h0; cnt_wr = 1; cnt_wd = 16'h1; cyc();
    rld_wr = 0; cnt_wr = 0;
    dcen = 1; dir = 0; run = 1; tick = 1; cyc();
    chk("R4 down to 0", cnt, 16'h0);
    cyc();
    chk("R4 wrap at rld 0", cnt, 16'hFFFF);
    chk("R7 ext toggled", {15'b0, ext}, 16'h0);

    // R5/R7 dcen low: up wrap, ext held
    dcen = 0; cyc();
    run = 0; tick = 0;
    chk("R5 up wrap to rld", cnt, 16'h0);
    chk("R7 ext held", {15'b0, ext}, 16'h0);

    // R1 async reset mid-run
    rst_n = 0; #1;
    chk("R1 reset cnt", cnt, 16'h0);
    chk("R1 reset rld", rld, 16'h0);
    summary();
  end
endmodule